// File: doc/BRIEF.md
# Fractional Clock Divider 10.8

This block turns a free-running input clock into a one-cycle tick enable whose average spacing is a fixed-point number of input clocks. The divisor word carries a 10-bit integer part A and an 8-bit fraction B, so the mean period is A + B/256 input clocks. Each individual period is either A or A+1 clocks long. An 8-bit phase accumulator decides which periods get the extra clock, so the longer periods are spread evenly rather than bunched together.

A new divisor is written through a load strobe into a holding register. It becomes active only at a tick boundary, or at once while the divider is disabled, so a period in flight is never cut short or stretched. Whenever the enable is low, the divider parks: no ticks, the period counter cleared, and the accumulator cleared.

Top module: `fdiv_top`

## Requirements
- R1: Out of reset tick_o is low and the active divisor is A=1, B=0, so with en_i held high and no load a tick appears on every input clock.
- R2: While en_i is low, tick_o stays low. The period counter and the accumulator return to zero, so after en_i rises the first tick comes A clocks later, counting the first enabled cycle as clock 1.
- R3: With B=0 the spacing between consecutive ticks is exactly A input clocks.
- R4: An integer part of A=0 behaves exactly like A=1.
- R5: With B nonzero every period is A or A+1 clocks. Any 256 consecutive periods that exclude the first period of a run contain exactly B periods of A+1 clocks.
- R6: Number the periods k=1,2,... from a rising en_i or from the tick that activated a new divisor. Period 1 is A clocks. For k>=2, period k is A+1 clocks exactly when floor((k-1)*B/256) > floor((k-2)*B/256).
- R7: When a load is pending with en_i high, the new divisor takes effect at the next tick. The period after that tick uses the new A and starts at k=1 of R6.
- R8: A load strobe given with en_i low, with en_i still low on the following cycle, is active for the first period after en_i rises.
- R9: When several loads arrive before a tick, only the most recent divisor is applied.
- R10: A pending load does not change the length of the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low parks the divider |
| load_i | input | 1 | Strobe capturing div_i into the holding register |
| div_i | input | 18 | Divisor word: [17:8] integer A, [7:0] fraction B |
| tick_o | output | 1 | One-cycle tick at the end of each period |

## Verification
The tick output is a combinational function of registered state and en_i. It therefore answers in the same cycle as en_i, and a period ends in the cycle where the counter reaches its last value. A load strobe reaches the holding register one clock later. It is applied on the next edge at which a tick is present or en_i is low, so it governs the period that starts after that edge. The bench drives inputs just after a rising edge and compares tick_o at the falling edge against a cycle model that follows these latencies. It also collects the measured tick intervals and checks them against the pattern and window counts of R3 to R10.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned DEF_INT_W  = 10;
  localparam int unsigned DEF_FRAC_W = 8;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_CLEAR = 2'd1,
    ACC_STEP  = 2'd2
  } acc_op_e;
endpackage

// File: rtl/fdiv_load.sv
module fdiv_load #(
  parameter int unsigned INT_W  = fdiv_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fdiv_pkg::DEF_FRAC_W,
  localparam int unsigned DIV_W = INT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              apply_i,
  output logic              pend_v_o,
  output logic [INT_W-1:0]  act_a_o,
  output logic [FRAC_W-1:0] act_b_o
);
  logic [DIV_W-1:0] pend_q;
  logic             pend_v_q;
  logic [INT_W-1:0] act_a_q;
  logic [FRAC_W-1:0] act_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (load_i) begin
      pend_q   <= div_i;
      pend_v_q <= 1'b1;
    end else if (apply_i) begin
      pend_v_q <= 1'b0;
    end
  end

  // active divisor resets to 1.0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_a_q <= INT_W'(1);
      act_b_q <= '0;
    end else if (apply_i) begin
      act_a_q <= pend_q[DIV_W-1:FRAC_W];
      act_b_q <= pend_q[FRAC_W-1:0];
    end
  end

  assign pend_v_o = pend_v_q;
  assign act_a_o  = act_a_q;
  assign act_b_o  = act_b_q;

  p_act_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable({act_a_q, act_b_q}));

  p_pend_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && !load_i) |=> !pend_v_q);
endmodule

// File: rtl/fdiv_acc.sv
module fdiv_acc
  import fdiv_pkg::*;
#(
  parameter int unsigned FRAC_W = fdiv_pkg::DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_op_e           op_i,
  input  logic [FRAC_W-1:0] b_i,
  output logic              extra_o
);
  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else begin
      unique case (op_i)
        ACC_CLEAR: begin
          acc_q   <= '0;
          extra_q <= 1'b0;
        end
        ACC_STEP: begin
          acc_q   <= sum[FRAC_W-1:0];
          extra_q <= sum[FRAC_W];  // carry stretches next period
        end
        default: ;
      endcase
    end
  end

  assign extra_o = extra_q;

  p_extra_needs_frac_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_q |-> (b_i != '0));
endmodule

// File: rtl/fdiv_cnt.sv
module fdiv_cnt #(
  parameter int unsigned INT_W = fdiv_pkg::DEF_INT_W,
  localparam int unsigned LEN_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INT_W-1:0] a_i,
  input  logic             extra_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W-1:0] a_eff;
  logic [LEN_W-1:0] len;
  logic             last;

  assign a_eff  = (a_i == '0) ? INT_W'(1) : a_i;
  assign len    = {1'b0, a_eff} + LEN_W'(extra_i);
  assign last   = ({1'b0, cnt_q} == len - LEN_W'(1));
  assign tick_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (last)   cnt_q <= '0;
    else             cnt_q <= cnt_q + INT_W'(1);
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < len);

  p_idle_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter int unsigned INT_W  = fdiv_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fdiv_pkg::DEF_FRAC_W,
  localparam int unsigned DIV_W = INT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic              pend_v;
  logic              apply;
  logic [INT_W-1:0]  act_a;
  logic [FRAC_W-1:0] act_b;
  logic              extra;
  logic              tick;
  acc_op_e           acc_op;

  // switch divisor only between periods
  assign apply = pend_v && (tick || !en_i);

  always_comb begin
    if (!en_i || apply) acc_op = ACC_CLEAR;
    else if (tick)      acc_op = ACC_STEP;
    else                acc_op = ACC_HOLD;
  end

  fdiv_load #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .div_i    (div_i),
    .apply_i  (apply),
    .pend_v_o (pend_v),
    .act_a_o  (act_a),
    .act_b_o  (act_b)
  );

  fdiv_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (acc_op),
    .b_i     (act_b),
    .extra_o (extra)
  );

  fdiv_cnt #(.INT_W(INT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .a_i     (act_a),
    .extra_i (extra),
    .tick_o  (tick)
  );

  assign tick_o = tick;

  p_apply_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_v && !tick_o) |=> pend_v);
endmodule

// File: tb/tb_fdiv_top.sv
module tb_fdiv_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        load_i = 1'b0;
  logic [17:0] div_i = '0;
  logic        tick_o;

  always #5 clk = ~clk;

  fdiv_top dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (load_i),
    .div_i  (div_i),
    .tick_o (tick_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string cur_req = "R1";
  int q[$];
  int last_tick = -1;
  int ticks_seen = 0;

  // reference model state
  int m_cnt = 0, m_acc = 0, m_extra = 0;
  int m_a = 1, m_b = 0, m_pa = 0, m_pb = 0, m_pv = 0;

  function automatic void chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endfunction

  function automatic int aeff(int a);
    return (a == 0) ? 1 : a;
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      int exp_t;
      int apply;
      cyc++;
      exp_t = (en_i && (m_cnt == aeff(m_a) + m_extra - 1)) ? 1 : 0;
      chk(cur_req, int'(tick_o), exp_t, "tick per cycle");
      if (tick_o) begin
        if (last_tick >= 0) q.push_back(cyc - last_tick);
        last_tick = cyc;
        ticks_seen++;
      end
      if (!en_i) last_tick = -1;
      apply = (m_pv != 0) && (exp_t != 0 || !en_i);
      if (!en_i) begin
        m_cnt = 0; m_acc = 0; m_extra = 0;
      end else if (exp_t != 0) begin
        m_cnt = 0;
        if (apply) begin
          m_acc = 0; m_extra = 0;
        end else begin
          m_extra = (m_acc + m_b) / 256;
          m_acc = (m_acc + m_b) % 256;
        end
      end else begin
        m_cnt++;
      end
      if (apply) begin
        m_a = m_pa; m_b = m_pb;
      end
      if (load_i) begin
        m_pv = 1; m_pa = int'(div_i[17:8]); m_pb = int'(div_i[7:0]);
      end else if (apply) begin
        m_pv = 0;
      end
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(int a, int b);
    load_i = 1'b1;
    div_i  = {10'(a), 8'(b)};
    step(1);
    load_i = 1'b0;
  endtask

  task automatic idle_load(int a, int b);
    en_i = 1'b0;
    step(1);
    load(a, b);
    step(2);
    q.delete();
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick_o);
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(string req, int v, int from);
    int bad = 0;
    for (int i = from; i < q.size(); i++) if (q[i] != v) bad++;
    chk(req, bad, 0, "intervals off nominal");
  endtask

  task automatic check_frac(string req, int a, int b, int n);
    int l0 = 0, l1 = 0, bad = 0, mis = 0;
    chk(req, (q.size() >= n) ? 1 : 0, 1, "enough intervals");
    if (q.size() >= n) begin
      for (int i = 0; i < n; i++) begin
        if (q[i] != a && q[i] != a + 1) bad++;
        // q[i] is period k=i+2
        if ((q[i] == a + 1) != (((i + 1) * b) / 256 > (i * b) / 256)) mis++;
        if (i < 256 && q[i] == a + 1) l0++;
        if (i >= n - 256 && q[i] == a + 1) l1++;
      end
      chk("R5", bad, 0, "periods not A or A+1");
      chk("R5", l0, b, "long periods, first window");
      chk("R5", l1, b, "long periods, later window");
      chk("R6", mis, 0, "long period placement");
    end
  endtask

  initial begin
    int t0;
    // R1: reset state
    step(2);
    @(negedge clk);
    chk("R1", int'(tick_o), 0, "tick in reset");
    @(posedge clk); #1;
    rst_ni = 1'b1;
    en_i = 1'b1;
    t0 = ticks_seen;
    step(10);
    chk("R1", ticks_seen - t0, 10, "ticks at default divisor");

    // R8 then R3: load while idle, A=5
    cur_req = "R8";
    idle_load(5, 0);
    cur_req = "R3";
    en_i = 1'b1;
    step(60);
    chk("R3", (q.size() >= 10) ? 1 : 0, 1, "interval count");
    check_all("R3", 5, 0);

    // R4: A=0 acts as A=1
    cur_req = "R4";
    idle_load(0, 0);
    en_i = 1'b1;
    step(20);
    chk("R4", (q.size() >= 15) ? 1 : 0, 1, "interval count");
    check_all("R4", 1, 0);

    // R5/R6: A=2, B=37
    cur_req = "R5";
    idle_load(2, 37);
    en_i = 1'b1;
    step(1400);
    check_frac("R6", 2, 37, 356);

    // R5: A=1, B=255
    idle_load(1, 255);
    en_i = 1'b1;
    step(700);
    check_frac("R5", 1, 255, 300);

    // R10/R7: load mid-period while running
    cur_req = "R10";
    idle_load(4, 0);
    en_i = 1'b1;
    step(10);
    wait_tick();
    q.delete();
    load(7, 0);
    cur_req = "R7";
    step(60);
    chk("R10", (q.size() > 0) ? q[0] : -1, 4, "period in flight");
    check_all("R7", 7, 1);

    // R9: two loads before a tick
    cur_req = "R9";
    idle_load(20, 0);
    en_i = 1'b1;
    wait_tick();
    q.delete();
    load(3, 0);
    load(9, 0);
    step(80);
    chk("R9", (q.size() > 0) ? q[0] : -1, 20, "period in flight");
    check_all("R9", 9, 1);

    // R2: disable mid-period
    cur_req = "R2";
    step(4);
    en_i = 1'b0;
    t0 = ticks_seen;
    step(15);
    chk("R2", ticks_seen - t0, 0, "ticks while disabled");
    q.delete();
    en_i = 1'b1;
    t0 = cyc;
    wait_tick();
    chk("R2", cyc - t0, 9, "first tick after enable");
    step(30);
    check_all("R2", 9, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule